// File: doc/BRIEF.md
# UART Scratchpad-Swap Register Bank

This block holds the small group of host-visible registers that sit around the scratch location of a UART host interface. One address can change meaning. With the swap input low, that address is an ordinary 8-bit scratch register. With the swap input high, a write to it sets a 2-bit FIFO-level mode, and a read from it returns a FIFO occupancy count taken from the RX or TX count inputs.

One of the modes returns the RX count and the TX count in turn on successive reads. A host can therefore poll both occupancies through one address with no extra register writes.

The bank also holds three other registers:
- the 16-bit baud divisor;
- a write-only threshold register, whose target (RX or TX threshold) is chosen by a select input;
- the divisor addresses, which return a fixed identification byte and a revision byte whenever the whole divisor is zero.

Host cycles are single-clock strobes qualified by chip select. Read data is captured at the read strobe and presented from a register on the next cycle.

Top module: `uart_spr_bank`

## Requirements
- R1: After reset the scratch register holds 0xFF, and the level mode is 00. Both thresholds, the divisor and the read-data output are 0. The alternation pointer selects RX.
- R2: With swap low, a write to address 7 stores all 8 data bits in the scratch register, and a read of address 7 returns them. The level mode and the alternation pointer are not changed.
- R3: With swap high, a write to address 7 loads data bits 1:0 into the level mode. Bits 7:2 are ignored, and the scratch register keeps its value.
- R4: With swap high, a read of address 7 returns the RX count when the mode is 00 or 10, and the TX count when the mode is 01.
- R5: With swap high and mode 11, successive reads of address 7 return RX, TX, RX, TX and so on, starting with RX.
- R6: Every swap-high write to address 7 sets the alternation pointer back to RX, including a write of the same mode value.
- R7: A write to address 2 loads the RX threshold when the target select is 0, and the TX threshold when it is 1. The other threshold is unchanged, and a read of address 2 returns 0.
- R8: Addresses 0 and 1 write the low and high divisor bytes. When the divisor is nonzero, reads return those bytes. The 16-bit divisor is always visible on its output.
- R9: While the divisor is 0x0000, a read of address 0 returns the ID byte 0x10, and a read of address 1 returns the revision byte 0x01.
- R10: Read data changes only in the cycle after a read strobe (chip select and read high, write low). It then holds the value selected with the inputs sampled at that strobe.
- R11: The alternation pointer moves only on a swap-high read of address 7 in mode 11. Reads with swap low and reads in the other modes leave it in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select qualifying both strobes |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wr_i | input | 1 | Write strobe, one cycle per access |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| swap_i | input | 1 | Turns address 7 into the mode/level port |
| trg_sel_i | input | 1 | Threshold target: 0 RX, 1 TX |
| rx_cnt_i | input | 8 | RX FIFO occupancy |
| tx_cnt_i | input | 8 | TX FIFO occupancy |
| divisor_o | output | 16 | Baud divisor |
| rx_trig_o | output | 8 | RX threshold |
| tx_trig_o | output | 8 | TX threshold |

## Verification
A wrong alternation pointer shows up on the very next mode-11 read as the wrong FIFO count. Rewriting the mode must restart the pattern, so a pointer that is not cleared shows up within one read after the rewrite. A mode field that takes the wrong bits, or a scratch register disturbed by swap-high writes, appears on the first read that depends on it, one cycle after the strobe. Divisor and threshold faults appear directly on their output ports in the cycle after the write, and on the ID/revision reads whenever the divisor is zero.

// File: rtl/uart_spr_pkg.sv
package uart_spr_pkg;
  localparam int unsigned SPR_AW  = 3;
  localparam int unsigned N_SLOTS = 4;

  // slot order: divisor low, divisor high, threshold, scratch/level
  localparam int unsigned SLOT_DLO = 0;
  localparam int unsigned SLOT_DHI = 1;
  localparam int unsigned SLOT_TRG = 2;
  localparam int unsigned SLOT_SPR = 3;
  localparam logic [N_SLOTS*SPR_AW-1:0] SLOT_ADDRS = {3'd7, 3'd2, 3'd1, 3'd0};

  typedef enum logic [1:0] {
    LVL_RX    = 2'b00,
    LVL_TX    = 2'b01,
    LVL_RX2   = 2'b10,
    LVL_ALTER = 2'b11
  } lvl_mode_e;
endpackage

// File: rtl/spr_bus_decode.sv
module spr_bus_decode
  import uart_spr_pkg::*;
(
  input  logic              cs_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [SPR_AW-1:0] addr_i,
  output logic              rd_any_o,
  output logic [N_SLOTS-1:0] rd_sel_o,
  output logic [N_SLOTS-1:0] wr_sel_o
);
  logic wr_ev;
  assign wr_ev    = cs_i & wr_i;
  assign rd_any_o = cs_i & rd_i & ~wr_i;  // write wins a collision

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
    logic hit;
    assign hit         = (addr_i == SLOT_ADDRS[g*SPR_AW +: SPR_AW]);
    assign rd_sel_o[g] = rd_any_o & hit;
    assign wr_sel_o[g] = wr_ev & hit;
  end
endmodule

// File: rtl/spr_level_sel.sv
module spr_level_sel
  import uart_spr_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_wr_i,
  input  logic [1:0]    mode_wdata_i,
  input  logic          lvl_rd_i,
  input  logic [DW-1:0] rx_cnt_i,
  input  logic [DW-1:0] tx_cnt_i,
  output logic [DW-1:0] level_o,
  output lvl_mode_e     mode_o,
  output logic          alt_tx_o
);
  lvl_mode_e mode_q;
  logic      alt_tx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= LVL_RX;
      alt_tx_q <= 1'b0;
    end else if (mode_wr_i) begin
      mode_q   <= lvl_mode_e'(mode_wdata_i);
      alt_tx_q <= 1'b0;
    end else if (lvl_rd_i && mode_q == LVL_ALTER) begin
      alt_tx_q <= ~alt_tx_q;
    end
  end

  always_comb begin
    unique case (mode_q)
      LVL_TX:    level_o = tx_cnt_i;
      LVL_ALTER: level_o = alt_tx_q ? tx_cnt_i : rx_cnt_i;
      default:   level_o = rx_cnt_i;
    endcase
  end

  assign mode_o   = mode_q;
  assign alt_tx_o = alt_tx_q;
endmodule

// File: rtl/spr_cfg_regs.sv
module spr_cfg_regs
  import uart_spr_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_SLOTS-1:0] wr_sel_i,
  input  logic               swap_i,
  input  logic               trg_sel_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      scratch_o,
  output logic [2*DW-1:0]    divisor_o,
  output logic [DW-1:0]      rx_trig_o,
  output logic [DW-1:0]      tx_trig_o
);
  logic [DW-1:0] scratch_q, div_lo_q, div_hi_q, rx_trig_q, tx_trig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scratch_q <= '1;
      div_lo_q  <= '0;
      div_hi_q  <= '0;
      rx_trig_q <= '0;
      tx_trig_q <= '0;
    end else begin
      if (wr_sel_i[SLOT_SPR] && !swap_i) scratch_q <= wdata_i;
      if (wr_sel_i[SLOT_DLO])            div_lo_q  <= wdata_i;
      if (wr_sel_i[SLOT_DHI])            div_hi_q  <= wdata_i;
      if (wr_sel_i[SLOT_TRG]) begin
        if (trg_sel_i) tx_trig_q <= wdata_i;
        else           rx_trig_q <= wdata_i;
      end
    end
  end

  assign scratch_o = scratch_q;
  assign divisor_o = {div_hi_q, div_lo_q};
  assign rx_trig_o = rx_trig_q;
  assign tx_trig_o = tx_trig_q;
endmodule

// File: rtl/uart_spr_bank.sv
module uart_spr_bank
  import uart_spr_pkg::*;
#(
  parameter int unsigned   DW      = 8,
  parameter logic [DW-1:0] DEV_ID  = 8'h10,
  parameter logic [DW-1:0] DEV_REV = 8'h01
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [SPR_AW-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic              swap_i,
  input  logic              trg_sel_i,
  input  logic [DW-1:0]     rx_cnt_i,
  input  logic [DW-1:0]     tx_cnt_i,
  output logic [2*DW-1:0]   divisor_o,
  output logic [DW-1:0]     rx_trig_o,
  output logic [DW-1:0]     tx_trig_o
);
  logic               rd_any;
  logic [N_SLOTS-1:0] rd_sel, wr_sel;
  logic [DW-1:0]      scratch, level, rd_mux, rdata_q;
  logic [2*DW-1:0]    divisor;
  lvl_mode_e          mode_q;
  logic               alt_tx;
  logic               div_zero;

  spr_bus_decode u_dec (
    .cs_i     (cs_i),
    .rd_i     (rd_i),
    .wr_i     (wr_i),
    .addr_i   (addr_i),
    .rd_any_o (rd_any),
    .rd_sel_o (rd_sel),
    .wr_sel_o (wr_sel)
  );

  spr_level_sel #(.DW(DW)) u_lvl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mode_wr_i    (wr_sel[SLOT_SPR] & swap_i),
    .mode_wdata_i (wdata_i[1:0]),
    .lvl_rd_i     (rd_sel[SLOT_SPR] & swap_i),
    .rx_cnt_i     (rx_cnt_i),
    .tx_cnt_i     (tx_cnt_i),
    .level_o      (level),
    .mode_o       (mode_q),
    .alt_tx_o     (alt_tx)
  );

  spr_cfg_regs #(.DW(DW)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_sel_i  (wr_sel),
    .swap_i    (swap_i),
    .trg_sel_i (trg_sel_i),
    .wdata_i   (wdata_i),
    .scratch_o (scratch),
    .divisor_o (divisor),
    .rx_trig_o (rx_trig_o),
    .tx_trig_o (tx_trig_o)
  );

  assign div_zero = (divisor == '0);

  always_comb begin
    rd_mux = '0;
    if (rd_sel[SLOT_DLO]) rd_mux = div_zero ? DEV_ID  : divisor[DW-1:0];
    if (rd_sel[SLOT_DHI]) rd_mux = div_zero ? DEV_REV : divisor[2*DW-1:DW];
    if (rd_sel[SLOT_SPR]) rd_mux = swap_i ? level : scratch;
    // threshold slot and unmapped addresses read as zero
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_q <= '0;
    else if (rd_any) rdata_q <= rd_mux;
  end

  assign rdata_o   = rdata_q;
  assign divisor_o = divisor;
endmodule

// File: rtl/uart_spr_bank_chk.sv
module uart_spr_bank_chk
  import uart_spr_pkg::*;
#(
  parameter int unsigned   DW      = 8,
  parameter logic [DW-1:0] DEV_ID  = 8'h10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic [SPR_AW-1:0] addr_i,
  input logic [DW-1:0]     wdata_i,
  input logic [DW-1:0]     rdata_o,
  input logic              swap_i,
  input logic              trg_sel_i,
  input logic [DW-1:0]     tx_cnt_i,
  input logic [2*DW-1:0]   divisor_o,
  input logic [DW-1:0]     rx_trig_o,
  input logic [DW-1:0]     tx_trig_o,
  input logic [1:0]        mode_i,
  input logic              alt_tx_i
);
  logic rd_ev, wr_ev, spr_rd, spr_wr, trg_wr, div_wr;
  assign rd_ev  = cs_i & rd_i & ~wr_i;
  assign wr_ev  = cs_i & wr_i;
  assign spr_rd = rd_ev & (addr_i == 3'd7) & swap_i;
  assign spr_wr = wr_ev & (addr_i == 3'd7) & swap_i;
  assign trg_wr = wr_ev & (addr_i == 3'd2);
  assign div_wr = wr_ev & (addr_i[2:1] == 2'b00);

  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_ev |=> $stable(rdata_o)); // R10
  AST_TRIG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trg_wr |=> $stable(rx_trig_o) && $stable(tx_trig_o)); // R7
  AST_TRIG_RX_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trg_wr && !trg_sel_i |=> $stable(tx_trig_o) && rx_trig_o == $past(wdata_i)); // R7
  AST_DIV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !div_wr |=> $stable(divisor_o)); // R8
  AST_ID_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ev && addr_i == 3'd0 && divisor_o == '0 |=> rdata_o == DEV_ID); // R9
  AST_MODE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spr_wr |=> !alt_tx_i && mode_i == $past(wdata_i[1:0])); // R6
  AST_ALT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spr_rd && mode_i == 2'b11 |=> alt_tx_i != $past(alt_tx_i)); // R5
  AST_TX_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spr_rd && mode_i == 2'b01 |=> rdata_o == $past(tx_cnt_i)); // R4
  AST_PTR_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !spr_wr && !(spr_rd && mode_i == 2'b11) |=> $stable(alt_tx_i)); // R11
endmodule

bind uart_spr_bank uart_spr_bank_chk #(.DW(DW), .DEV_ID(DEV_ID)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_i      (cs_i),
  .rd_i      (rd_i),
  .wr_i      (wr_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .swap_i    (swap_i),
  .trg_sel_i (trg_sel_i),
  .tx_cnt_i  (tx_cnt_i),
  .divisor_o (divisor_o),
  .rx_trig_o (rx_trig_o),
  .tx_trig_o (tx_trig_o),
  .mode_i    (mode_q),
  .alt_tx_i  (alt_tx)
);

// File: tb/tb_uart_spr_bank.sv
module tb_uart_spr_bank;
  logic       clk_i = 0, rst_ni = 0;
  logic       cs_i = 0, rd_i = 0, wr_i = 0, swap_i = 0, trg_sel_i = 0;
  logic [2:0] addr_i = 0;
  logic [7:0] wdata_i = 0, rx_cnt_i = 0, tx_cnt_i = 0;
  logic [7:0] rdata_o, rx_trig_o, tx_trig_o;
  logic [15:0] divisor_o;

  uart_spr_bank dut (.*);

  always #2 clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference state
  logic [7:0]  m_spr = 8'hFF, m_rxt = 0, m_txt = 0;
  logic [15:0] m_div = 0;
  logic [1:0]  m_mode = 0;
  bit          m_ptr = 0;

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(logic [2:0] a, bit sw, logic [7:0] rx, logic [7:0] tx);
    case (a)
      3'd0: return (m_div == 0) ? 8'h10 : m_div[7:0];
      3'd1: return (m_div == 0) ? 8'h01 : m_div[15:8];
      3'd7: begin
        if (!sw) return m_spr;
        case (m_mode)
          2'b01:   return tx;
          2'b11:   return m_ptr ? tx : rx;
          default: return rx;
        endcase
      end
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_of(logic [2:0] a, bit sw);
    if (a == 3'd7) return !sw ? "R2" : (m_mode == 2'b11 ? "R5" : "R4");
    if (a == 3'd2) return "R7";
    if (a <= 3'd1) return (m_div == 0) ? "R9" : "R8";
    return "R10";
  endfunction

  task automatic do_wr(logic [2:0] a, logic [7:0] d, bit sw, bit ts);
    @(negedge clk_i);
    cs_i = 1; wr_i = 1; addr_i = a; wdata_i = d; swap_i = sw; trg_sel_i = ts;
    @(negedge clk_i);
    cs_i = 0; wr_i = 0;
    case (a)
      3'd0: m_div[7:0]  = d;
      3'd1: m_div[15:8] = d;
      3'd2: if (ts) m_txt = d; else m_rxt = d;
      3'd7: if (sw) begin m_mode = d[1:0]; m_ptr = 0; end else m_spr = d;
      default: ;
    endcase
  endtask

  task automatic do_rd(logic [2:0] a, bit sw, logic [7:0] rx, logic [7:0] tx, string req);
    logic [7:0] e;
    @(negedge clk_i);
    cs_i = 1; rd_i = 1; addr_i = a; swap_i = sw; rx_cnt_i = rx; tx_cnt_i = tx;
    e = exp_read(a, sw, rx, tx);
    if (a == 3'd7 && sw && m_mode == 2'b11) m_ptr = ~m_ptr;
    @(negedge clk_i);
    cs_i = 0; rd_i = 0;
    rx_cnt_i = ~rx; tx_cnt_i = ~tx;  // later count changes must not leak in (R10)
    chk(req, {8'h0, rdata_o}, {8'h0, e});
  endtask

  task automatic chk_outs();
    chk("R7", {8'h0, rx_trig_o}, {8'h0, m_rxt});
    chk("R7", {8'h0, tx_trig_o}, {8'h0, m_txt});
    chk("R8", divisor_o, m_div);
  endtask

  initial begin
    int unsigned seed = 32'h5EED_1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1", {8'h0, rdata_o}, 16'h0);
    chk("R1", divisor_o, 16'h0);
    chk("R1", {rx_trig_o, tx_trig_o}, 16'h0);
    rst_ni = 1;
    do_rd(3'd7, 0, 8'h00, 8'h00, "R1");
    do_rd(3'd7, 1, 8'h21, 8'h43, "R1");   // mode 00 after reset gives RX
    // R9 ID and revision while divisor zero
    do_rd(3'd0, 0, 0, 0, "R9");
    do_rd(3'd1, 0, 0, 0, "R9");
    // R2 scratch round trip
    do_wr(3'd7, 8'hA5, 0, 0);
    do_rd(3'd7, 0, 0, 0, "R2");
    // R3 swap-high write sets mode, scratch kept, upper bits ignored
    do_wr(3'd7, 8'hFD, 1, 0);             // mode 01
    do_rd(3'd7, 1, 8'h11, 8'h22, "R3");
    do_rd(3'd7, 0, 0, 0, "R3");
    // R4 each non-alternating mode
    do_wr(3'd7, 8'h00, 1, 0); do_rd(3'd7, 1, 8'h31, 8'h32, "R4");
    do_wr(3'd7, 8'h01, 1, 0); do_rd(3'd7, 1, 8'h41, 8'h42, "R4");
    do_wr(3'd7, 8'h02, 1, 0); do_rd(3'd7, 1, 8'h51, 8'h52, "R4");
    // R5 alternating sequence of six reads
    do_wr(3'd7, 8'h03, 1, 0);
    for (int i = 0; i < 6; i++) do_rd(3'd7, 1, 8'h60 + 8'(i), 8'h70 + 8'(i), "R5");
    // R11 swap-low read leaves pointer; next alt read is RX after 6 reads
    do_rd(3'd7, 0, 0, 0, "R11");
    do_rd(3'd7, 1, 8'h81, 8'h82, "R11");  // RX, pointer now TX
    // R6 rewrite same mode restarts at RX
    do_wr(3'd7, 8'h03, 1, 0);
    do_rd(3'd7, 1, 8'h91, 8'h92, "R6");
    do_rd(3'd7, 1, 8'h93, 8'h94, "R6");
    // R10 write and idle cycles keep read data
    do_wr(3'd2, 8'h37, 0, 1);
    repeat (2) @(negedge clk_i);
    chk("R10", {8'h0, rdata_o}, 16'h0094);
    chk_outs();
    // R8 nonzero divisor reads back bytes
    do_wr(3'd1, 8'h00, 0, 0); do_wr(3'd0, 8'h0C, 0, 0);
    do_rd(3'd0, 0, 0, 0, "R8"); do_rd(3'd1, 0, 0, 0, "R8");
    chk_outs();
    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [2:0] a;
      bit sw;
      case ($urandom % 4)
        0: a = 3'd0; 1: a = 3'd1; 2: a = 3'd2; default: a = 3'd7;
      endcase
      if ($urandom % 10 == 0) a = 3'($urandom);
      sw = ($urandom % 3) != 0;
      if ($urandom % 2) begin
        logic [7:0] d;
        d = 8'($urandom);
        if (a <= 3'd1 && ($urandom % 2)) d = 8'h00;
        do_wr(a, d, sw, 1'($urandom));
        chk_outs();
      end else begin
        do_rd(a, sw, 8'($urandom), 8'($urandom), tag_of(a, sw));
      end
    end
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk_i);
      cyc++;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog got=%0d exp=done", cyc);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule